// File: doc/BRIEF.md
# Stereo Audio Sample Double Buffer

This block sits between a processor bus and the serializer of a two-channel digital audio transmitter. Software writes 24-bit samples to a single write-only data address. Successive writes land alternately in a channel A holding register and a channel B holding register. The serializer timing logic sends two single-cycle strobes: one at the start of each frame and one at the start of the channel B subframe.

On a frame strobe, the block presents the channel A sample on its load port. In the same cycle it moves the channel B sample into a hidden buffer. On the channel B strobe it presents that buffered sample. Because of this second stage, software has almost a whole frame to write the next pair.

A frame strobe also forces the write pointer back to channel A. It sets an empty flag, which drives an interrupt request. If a frame strobe arrives while the flag is still set, a sticky underrun bit is raised and the previous samples are sent again.

Top module: `audio_pair_buffer`

## Requirements
- R1: After reset, `load_valid_o`, `load_data_o` and `irq_o` are 0. A control read (address 1) returns 0. A status read (address 2) returns 1, meaning empty set and underrun clear.
- R2: The data address (0) is write-only. A read of it returns 0.
- R3: While enabled, writes to address 0 go to holding register A, then B, then A, and so on.
- R4: While enabled, a frame strobe makes `load_valid_o` high for exactly the next cycle. In that cycle `load_data_o` equals register A as it was at the strobe.
- R5: While enabled, a channel B strobe makes `load_valid_o` high the next cycle. `load_data_o` then carries register B as captured at the last frame strobe, not any later write to B.
- R6: A frame strobe returns the write pointer to A. A data write in the same cycle is applied after the transfer, so it lands in A and does not alter the sample sent.
- R7: Status bit 0 (empty) is set by every enabled frame strobe. It is cleared by a write that lands in register B, unless a frame strobe occurs in that cycle.
- R8: Control bit 0 is enable and bit 1 is interrupt enable, both written at address 1. `irq_o` is high exactly when enable, interrupt enable and empty are all set.
- R9: Status bit 1 (underrun) is set when an enabled frame strobe sees empty already set, and the stale register A value is sent. Reading status clears it. A set in the same cycle wins over the clear.
- R10: While enable is 0, data writes are ignored, the pointer is held at A, empty is held set, and neither strobe produces `load_valid_o`.
- R11: If both strobes arrive in the same cycle, the frame strobe takes effect and the channel B strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 2 | Register address: 0 data, 1 control, 2 status |
| wdata_i | input | 24 | Bus write data |
| rdata_o | output | 24 | Bus read data (combinational) |
| frame_start_i | input | 1 | Frame-start strobe from serializer timing |
| chb_start_i | input | 1 | Channel B subframe-start strobe |
| load_valid_o | output | 1 | Load strobe to the serializer |
| load_data_o | output | 24 | Sample for the serializer shift register |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- a frame strobe moves register A to the load port one cycle later;
- the load strobe stays quiet while the block is disabled;
- a frame strobe sets the empty flag, and a write to B clears it;
- underrun is raised when a frame strobe arrives with empty still set;
- the data address reads as zero;
- the interrupt request is never asserted without the empty flag.

Some behaviour can only be shown by the bench's scenarios:
- the buffered channel B value survives later writes to B;
- the pointer realigns to A when a write and a frame strobe collide;
- the underrun bit clears on a status read, except when a new underrun occurs in the same cycle;
- a frame strobe takes priority over a simultaneous channel B strobe.

// File: rtl/abuf_pkg.sv
package abuf_pkg;
  typedef enum logic {SLOT_A = 1'b0, SLOT_B = 1'b1} slot_e;
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int STAT_EMP_BIT = 0;
  localparam int STAT_UND_BIT = 1;
endpackage

// File: rtl/abuf_hold_regs.sv
module abuf_hold_regs import abuf_pkg::*; #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              frame_fire_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] hold_a_o,
  output logic [DATA_W-1:0] hold_b_o,
  output logic              b_wr_o
);
  slot_e ptr_q, ptr_eff;

  // frame strobe realigns the pointer before the write is applied
  assign ptr_eff = frame_fire_i ? SLOT_A : ptr_q;
  assign b_wr_o  = en_i && data_we_i && (ptr_eff == SLOT_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_a_o <= '0;
      hold_b_o <= '0;
      ptr_q    <= SLOT_A;
    end else if (!en_i) begin
      ptr_q <= SLOT_A;
    end else if (data_we_i) begin
      if (ptr_eff == SLOT_A) begin
        hold_a_o <= wdata_i;
        ptr_q    <= SLOT_B;
      end else begin
        hold_b_o <= wdata_i;
        ptr_q    <= SLOT_A;
      end
    end else if (frame_fire_i) begin
      ptr_q <= SLOT_A;
    end
  end
endmodule

// File: rtl/abuf_ctrl_regs.sv
module abuf_ctrl_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [1:0] ctrl_wdata_i,
  input  logic       frame_fire_i,
  input  logic       b_wr_i,
  input  logic       stat_rd_i,
  output logic       en_o,
  output logic       ie_o,
  output logic       empty_o,
  output logic       underrun_o,
  output logic       irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      ie_o       <= 1'b0;
      empty_o    <= 1'b1;
      underrun_o <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        en_o <= ctrl_wdata_i[0];
        ie_o <= ctrl_wdata_i[1];
      end
      if (!en_o || frame_fire_i) empty_o <= 1'b1;
      else if (b_wr_i)           empty_o <= 1'b0;
      // set beats read-clear
      if (frame_fire_i && empty_o) underrun_o <= 1'b1;
      else if (stat_rd_i)          underrun_o <= 1'b0;
    end
  end

  assign irq_o = en_o && ie_o && empty_o;
endmodule

// File: rtl/abuf_load_stage.sv
module abuf_load_stage #(
  parameter int DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_fire_i,
  input  logic              chb_fire_i,
  input  logic [DATA_W-1:0] hold_a_i,
  input  logic [DATA_W-1:0] hold_b_i,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o
);
  logic [DATA_W-1:0] chb_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chb_buf_q    <= '0;
      load_data_o  <= '0;
      load_valid_o <= 1'b0;
    end else if (frame_fire_i) begin
      load_data_o  <= hold_a_i;
      chb_buf_q    <= hold_b_i;
      load_valid_o <= 1'b1;
    end else if (chb_fire_i) begin
      load_data_o  <= chb_buf_q;
      load_valid_o <= 1'b1;
    end else begin
      load_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/audio_pair_buffer.sv
module audio_pair_buffer import abuf_pkg::*; #(
  parameter int                DATA_W    = 24,
  parameter int                ADDR_W    = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 2'd1,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 2'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              frame_start_i,
  input  logic              chb_start_i,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o,
  output logic              irq_o
);
  logic en, ie, empty, underrun, b_wr;
  logic frame_fire, chb_fire, data_we, ctrl_we, stat_rd;
  logic [DATA_W-1:0] hold_a, hold_b;

  assign data_we    = wr_en_i && (addr_i == DATA_ADDR);
  assign ctrl_we    = wr_en_i && (addr_i == CTRL_ADDR);
  assign stat_rd    = rd_en_i && (addr_i == STAT_ADDR);
  assign frame_fire = frame_start_i && en;
  assign chb_fire   = chb_start_i && en && !frame_start_i;

  abuf_hold_regs #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .en_i(en), .frame_fire_i(frame_fire), .data_we_i(data_we),
    .wdata_i, .hold_a_o(hold_a), .hold_b_o(hold_b), .b_wr_o(b_wr)
  );

  abuf_ctrl_regs u_ctrl (
    .clk_i, .rst_ni, .ctrl_we_i(ctrl_we), .ctrl_wdata_i(wdata_i[1:0]),
    .frame_fire_i(frame_fire), .b_wr_i(b_wr), .stat_rd_i(stat_rd),
    .en_o(en), .ie_o(ie), .empty_o(empty), .underrun_o(underrun), .irq_o
  );

  abuf_load_stage #(.DATA_W(DATA_W)) u_load (
    .clk_i, .rst_ni, .frame_fire_i(frame_fire), .chb_fire_i(chb_fire),
    .hold_a_i(hold_a), .hold_b_i(hold_b), .load_valid_o, .load_data_o
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (addr_i == CTRL_ADDR) begin
        rdata_o[CTRL_EN_BIT] = en;
        rdata_o[CTRL_IE_BIT] = ie;
      end else if (addr_i == STAT_ADDR) begin
        rdata_o[STAT_EMP_BIT] = empty;
        rdata_o[STAT_UND_BIT] = underrun;
      end
    end
  end
endmodule

// File: rtl/abuf_chk.sv
module abuf_chk #(
  parameter int DATA_W = 24,
  parameter int ADDR_W = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 2'd0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              load_valid_o,
  input logic [DATA_W-1:0] load_data_o,
  input logic              irq_o,
  input logic              en,
  input logic              empty,
  input logic              underrun,
  input logic              b_wr,
  input logic              frame_fire,
  input logic [DATA_W-1:0] hold_a
);
  // R4
  frame_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_fire |=> load_valid_o && load_data_o == $past(hold_a));
  // R10
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !load_valid_o);
  // R7
  empty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_fire |=> empty);
  // R7
  empty_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_wr && !frame_fire |=> !empty);
  // R9
  underrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_fire && empty |=> underrun);
  // R2
  wo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == DATA_ADDR |-> rdata_o == '0);
  // R8
  irq_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> empty);
endmodule

bind audio_pair_buffer abuf_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk_i, .rst_ni, .rd_en_i, .addr_i, .rdata_o, .load_valid_o, .load_data_o, .irq_o,
  .en, .empty, .underrun, .b_wr, .frame_fire, .hold_a
);

// File: tb/audio_pair_buffer_bench.sv
`timescale 1ns/1ps
module audio_pair_buffer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, fs = 0, cb = 0;
  logic [1:0] addr = 0;
  logic [23:0] wdata = 0, rdata, ld;
  logic lv, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_pair_buffer u_audio_pair_buffer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .frame_start_i(fs), .chb_start_i(cb),
    .load_valid_o(lv), .load_data_o(ld), .irq_o(irq)
  );

  // reference state, built from the requirements
  logic [23:0] m_a = 0, m_b = 0, m_buf = 0, m_ld = 0;
  logic m_ptr = 0, m_en = 0, m_ie = 0, m_emp = 1, m_und = 0, m_lv = 0;

  function automatic logic [23:0] exp_rd(input logic [1:0] a);
    if (a == 2'd1) return {22'd0, m_ie, m_en};
    if (a == 2'd2) return {22'd0, m_und, m_emp};
    return 24'd0;
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic w, input logic [1:0] a, input logic [23:0] d,
                     input logic r, input logic f, input logic c);
    logic ffire, cfire, pe;
    wr_en = w; addr = a; wdata = d; rd_en = r; fs = f; cb = c;
    #1;
    if (r) chk({tag, " read"}, rdata, exp_rd(a));
    ffire = f && m_en;
    cfire = c && m_en && !f;
    m_lv = ffire || cfire;
    if (ffire) begin m_ld = m_a; end
    else if (cfire) m_ld = m_buf;
    pe = ffire ? 1'b0 : m_ptr;
    if (f && m_und == 0 && ffire && m_emp) m_und = 1;
    else if (ffire && m_emp) m_und = 1;
    else if (r && a == 2'd2) m_und = 0;
    if (!m_en) begin m_ptr = 0; m_emp = 1; end
    else begin
      if (ffire) begin m_buf = m_b; m_emp = 1; end
      if (w && a == 2'd0) begin
        if (!pe) begin m_a = d; m_ptr = 1; end
        else begin m_b = d; m_ptr = 0; if (!ffire) m_emp = 0; end
      end else if (ffire) m_ptr = 0;
    end
    if (w && a == 2'd1) begin m_en = d[0]; m_ie = d[1]; end
    @(posedge clk); @(negedge clk);
    chk({tag, " load_valid"}, {23'd0, lv}, {23'd0, m_lv});
    chk({tag, " load_data"}, ld, m_ld);
    chk({tag, " irq"}, {23'd0, irq}, {23'd0, m_en && m_ie && m_emp});
    wr_en = 0; rd_en = 0; fs = 0; cb = 0;
  endtask

  task automatic wr(input string t, input logic [1:0] a, input logic [23:0] d); cyc(t, 1, a, d, 0, 0, 0); endtask
  task automatic rd(input string t, input logic [1:0] a); cyc(t, 0, a, 0, 1, 0, 0); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_a0d1));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 load_valid", {23'd0, lv}, 24'd0);
    chk("R1 load_data", ld, 24'd0);
    chk("R1 irq", {23'd0, irq}, 24'd0);
    rst_n = 1;
    @(negedge clk);
    rd("R1 ctrl", 2'd1);
    rd("R1 status", 2'd2);
    rd("R2", 2'd0);
    // R10 disabled: writes ignored, strobes dropped
    wr("R10", 2'd0, 24'h0badd0);
    cyc("R10", 0, 0, 0, 0, 1, 0);
    cyc("R10", 0, 0, 0, 0, 0, 1);
    wr("R8", 2'd1, 24'd3);
    chk("R8 irq on", {23'd0, irq}, 24'd1);
    // R3 alternation, R7 empty clear
    wr("R3", 2'd0, 24'h111111);
    wr("R3", 2'd0, 24'h222222);
    rd("R7", 2'd2);
    chk("R7 irq off", {23'd0, irq}, 24'd0);
    cyc("R4", 0, 0, 0, 0, 1, 0);
    chk("R4 A out", ld, 24'h111111);
    wr("R5", 2'd0, 24'h333333);
    wr("R5", 2'd0, 24'h444444);
    cyc("R5", 0, 0, 0, 0, 0, 1);
    chk("R5 buffered B", ld, 24'h222222);
    // R6 pointer realign
    wr("R6", 2'd0, 24'h555555);
    cyc("R6", 0, 0, 0, 0, 1, 0);
    chk("R6 sent", ld, 24'h555555);
    wr("R6", 2'd0, 24'h666666);
    cyc("R6 collide", 1, 2'd0, 24'h777777, 0, 1, 0);
    chk("R6 old A sent", ld, 24'h666666);
    wr("R6", 2'd0, 24'h888888);
    cyc("R6", 0, 0, 0, 0, 1, 0);
    chk("R6 A from collision", ld, 24'h777777);
    cyc("R5", 0, 0, 0, 0, 0, 1);
    chk("R5 B after collision", ld, 24'h888888);
    // R9 underrun, stale resend, clear, set-wins
    cyc("R9", 0, 0, 0, 0, 1, 0);
    chk("R9 stale", ld, 24'h777777);
    rd("R9", 2'd2);
    rd("R9 cleared", 2'd2);
    cyc("R9 set wins", 0, 2'd2, 0, 1, 1, 0);
    rd("R9 still set", 2'd2);
    // R11 both strobes
    wr("R11", 2'd0, 24'h9a9a9a);
    wr("R11", 2'd0, 24'hb1b1b1);
    cyc("R11", 0, 0, 0, 0, 1, 1);
    chk("R11 frame wins", ld, 24'h9a9a9a);
    // R10 disable mid-stream
    wr("R10", 2'd1, 24'd2);
    wr("R10", 2'd0, 24'hdead01);
    cyc("R10", 0, 0, 0, 0, 1, 0);
    rd("R10 status", 2'd2);
    wr("R10", 2'd1, 24'd1);
    cyc("R10", 0, 0, 0, 0, 1, 0);
    chk("R10 write dropped", ld, 24'h9a9a9a);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(0, 99);
      logic w = (k < 45);
      logic [1:0] a = (k < 40) ? 2'd0 : 2'($urandom_range(0, 3));
      logic [23:0] d = 24'($urandom);
      if (w && a == 2'd1) d[0] = ($urandom_range(0, 7) != 0);
      cyc("rand R3 R4 R5 R9", w, a, d, $urandom_range(0, 5) == 0,
          $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule